// File: doc/BRIEF.md
# SPI Flash Command Sequencer

This block is the byte-level protocol engine of a serial NOR flash slave. A bit shifter in front of it delivers one received byte per transfer through `rx_valid`/`rx_byte`. In the same accepted transfer the block registers the byte it returns on `tx_byte`, and the shifter sends that byte out during the next byte time. In idle the block treats each byte as an opcode. For commands that carry an address it collects the address and any dummy bytes. It then streams array data, issues one program request per data byte, or issues an erase request. It also returns a status byte or the identification bytes from a small buffer.

The block holds the write-enable latch. It reaches the storage array through a combinational read port and through single-cycle request pulses to an external program/erase engine. The array holds 2^ADDR_BITS bytes. Address bits above that width are dropped. Dual-lane and quad-lane opcodes are handled as ordinary single-lane byte streams. Only their address-plus-dummy byte counts differ, and for two of them the count depends on the manufacturer byte.

Top module: `spi_flash_cmd_seq`

## Requirements
- R1: After reset, `tx_byte` is 0x00, no request or error pulse is raised, and the write-enable latch is clear.
- R2: Opcodes 0x03, 0x02, 0xA2, 0x32, 0x20, 0x52 and 0xD8 take exactly 3 following bytes before acting. Opcodes 0x0B, 0x3B and 0x6B take exactly 4.
- R3: Opcode 0xBB takes 4 following bytes when the manufacturer byte `MFR_ID` is 0xEF or 0x01, and 5 otherwise. Opcode 0xEB takes 6 or 8 bytes under the same rule.
- R4: The first three collected bytes form the address, most significant first, and only the low ADDR_BITS bits are kept. In the read state each transfer returns the array byte at the current address, and the address then advances and wraps from the top of the array to 0.
- R5: In the page program state each received byte raises `prog_req` for one cycle, with `prog_addr` set to the current address and `prog_data` set to the byte. The address then advances.
- R6: 0x06 sets the write-enable latch and 0x04 clears it. 0x05 returns one status byte whose bit 1 is the latch and whose other bits are 0.
- R7: 0x9F returns `MFR_ID` followed by the two `DEV_ID` bytes, high byte first. When `EXT_ID` is nonzero, its high and low bytes follow. After the last byte the next byte is decoded as an opcode.
- R8: With the latch set, 0x01 collects one byte and then clears the latch. With the latch clear, 0x01 is ignored and the next byte is decoded as an opcode.
- R9: Opcodes 0x20, 0x52 and 0xD8 with the latch set raise `erase_req` for one cycle once the address is complete. `erase_kind` is 0, 1 or 2 respectively, and `erase_addr` is the collected address. With the latch clear they raise `err` instead.
- R10: 0xC7 with the latch set raises `erase_req` with `erase_kind` 3 (whole array). With the latch clear it raises `err`.
- R11: Opcode 0x00 does nothing. Any opcode not listed in R2 to R10 raises `err` for one cycle.
- R12: While `cs_n` is high the block returns to idle, clears its byte counters and ignores `rx_valid`. The write-enable latch keeps its value.
- R13: `tx_byte` changes only on an accepted transfer. It is 0x00 for transfers outside the read and reply states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| rx_valid | input | 1 | One received byte is offered this cycle |
| rx_byte | input | 8 | Received byte |
| tx_byte | output | 8 | Byte to return, registered at each accepted transfer |
| rd_addr | output | ADDR_BITS | Array read address |
| rd_data | input | 8 | Array data at `rd_addr`, same cycle |
| prog_req | output | 1 | One-cycle program request |
| prog_addr | output | ADDR_BITS | Byte address to program |
| prog_data | output | 8 | Byte to program |
| erase_req | output | 1 | One-cycle erase request |
| erase_kind | output | 2 | 0: 4 KiB, 1: 32 KiB, 2: sector, 3: whole array |
| erase_addr | output | ADDR_BITS | Address inside the region to erase |
| err | output | 1 | One-cycle flag for a rejected or unknown command |

## Verification
The properties assume that the shifter offers at most one byte per cycle and that `rd_data` reflects `rd_addr` within the same cycle. They also assume that bytes sent while `cs_n` is high carry no meaning. The bench keeps `rx_valid` to single-cycle pulses separated by idle cycles and models the array as a pure function of the address. It toggles `cs_n` only between transfers, apart from one deliberate byte sent while deselected. Two instances with different manufacturer and extended ID settings receive the same byte stream, so the byte counts that depend on the manufacturer are compared side by side.

// File: rtl/sfc_pkg.sv
// Shared types for the flash command sequencer.
// Assumes: erase kind codes are decoded by the external erase engine.
package sfc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_READ,
        ST_COLLECT,
        ST_REPLY
    } sfc_state_e;

    typedef enum logic [3:0] {
        OC_NOP,
        OC_READ,
        OC_PROG,
        OC_ERASE,
        OC_WRSR,
        OC_WREN,
        OC_WRDI,
        OC_STATUS,
        OC_ID,
        OC_BULK,
        OC_BAD
    } sfc_opclass_e;

    localparam logic [1:0] EK_4K     = 2'd0;
    localparam logic [1:0] EK_32K    = 2'd1;
    localparam logic [1:0] EK_SECTOR = 2'd2;
    localparam logic [1:0] EK_WHOLE  = 2'd3;

endpackage

// File: rtl/sfc_opcode_decode.sv
// Opcode classifier: maps one opcode byte to its command class, the number
// of address/dummy bytes that follow, and the erase kind.
// Assumes: MFR_ID is fixed at build time.
module sfc_opcode_decode
    import sfc_pkg::*;
#(
    parameter logic [7:0] MFR_ID = 8'h20
) (
    input  logic [7:0]   opcode,
    output sfc_opclass_e op_class,
    output logic [3:0]   need,
    output logic [1:0]   ekind
);
    localparam bit SHORT_IO = (MFR_ID == 8'hEF) || (MFR_ID == 8'h01);

    // classify the opcode
    always_comb begin
        op_class = OC_BAD;
        need     = 4'd0;
        ekind    = EK_4K;
        case (opcode)
            8'h00: op_class = OC_NOP;
            8'h03: begin op_class = OC_READ; need = 4'd3; end
            8'h0B, 8'h3B, 8'h6B: begin op_class = OC_READ; need = 4'd4; end
            8'hBB: begin op_class = OC_READ; need = SHORT_IO ? 4'd4 : 4'd5; end
            8'hEB: begin op_class = OC_READ; need = SHORT_IO ? 4'd6 : 4'd8; end
            8'h02, 8'hA2, 8'h32: begin op_class = OC_PROG; need = 4'd3; end
            8'h20: begin op_class = OC_ERASE; need = 4'd3; ekind = EK_4K; end
            8'h52: begin op_class = OC_ERASE; need = 4'd3; ekind = EK_32K; end
            8'hD8: begin op_class = OC_ERASE; need = 4'd3; ekind = EK_SECTOR; end
            8'hC7: begin op_class = OC_BULK; ekind = EK_WHOLE; end
            8'h01: begin op_class = OC_WRSR; need = 4'd1; end
            8'h06: op_class = OC_WREN;
            8'h04: op_class = OC_WRDI;
            8'h05: op_class = OC_STATUS;
            8'h9F: op_class = OC_ID;
            default: op_class = OC_BAD;
        endcase
    end
endmodule

// File: rtl/sfc_addr_counter.sv
// Current-address register: shifts in address bytes MSB first, keeping the
// low ADDR_BITS bits, and increments with natural wrap at the array size.
// Assumes: 9 <= ADDR_BITS <= 24; shift and increment are never both set.
module sfc_addr_counter #(
    parameter int ADDR_BITS = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift_en,
    input  logic                 inc_en,
    input  logic [7:0]           byte_in,
    output logic [ADDR_BITS-1:0] addr
);
    // load or advance the address
    always_ff @(posedge clk) begin
        if (!rst_n)        addr <= '0;
        else if (shift_en) addr <= {addr[ADDR_BITS-9:0], byte_in};
        else if (inc_en)   addr <= addr + 1'b1;
    end
endmodule

// File: rtl/sfc_reply_mux.sv
// Reply buffer: selects the status byte or the identification byte at a
// given index and flags the final byte of the reply.
// Assumes: idx stays below the reply length.
module sfc_reply_mux #(
    parameter logic [7:0]  MFR_ID = 8'h20,
    parameter logic [15:0] DEV_ID = 16'hBA16,
    parameter logic [15:0] EXT_ID = 16'h0000
) (
    input  logic       is_id,
    input  logic [2:0] idx,
    input  logic       wel,
    output logic [7:0] byte_out,
    output logic       last
);
    localparam logic [2:0] ID_LEN = (EXT_ID != 16'h0000) ? 3'd5 : 3'd3;

    // pick the byte and detect the end of the reply
    always_comb begin
        if (!is_id) begin
            byte_out = {6'b0, wel, 1'b0};
            last     = 1'b1;
        end else begin
            case (idx)
                3'd0:    byte_out = MFR_ID;
                3'd1:    byte_out = DEV_ID[15:8];
                3'd2:    byte_out = DEV_ID[7:0];
                3'd3:    byte_out = EXT_ID[15:8];
                default: byte_out = EXT_ID[7:0];
            endcase
            last = (idx == ID_LEN - 3'd1);
        end
    end
endmodule

// File: rtl/spi_flash_cmd_seq.sv
// Byte-level command sequencer of a serial NOR flash slave. It decodes
// opcodes, collects address and dummy bytes, streams reads, issues program
// and erase requests, and returns status and identification bytes.
// Assumes: at most one byte per cycle; rd_data is valid in the cycle that
// rd_addr is presented; the erase/program engine accepts single pulses.
module spi_flash_cmd_seq
    import sfc_pkg::*;
#(
    parameter int          ADDR_BITS = 16,
    parameter logic [7:0]  MFR_ID    = 8'h20,
    parameter logic [15:0] DEV_ID    = 16'hBA16,
    parameter logic [15:0] EXT_ID    = 16'h0000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n,
    input  logic                 rx_valid,
    input  logic [7:0]           rx_byte,
    output logic [7:0]           tx_byte,
    output logic [ADDR_BITS-1:0] rd_addr,
    input  logic [7:0]           rd_data,
    output logic                 prog_req,
    output logic [ADDR_BITS-1:0] prog_addr,
    output logic [7:0]           prog_data,
    output logic                 erase_req,
    output logic [1:0]           erase_kind,
    output logic [ADDR_BITS-1:0] erase_addr,
    output logic                 err
);
    sfc_state_e     state_q;
    sfc_opclass_e   cls_q;
    sfc_opclass_e   dec_class;
    logic [3:0]     dec_need;
    logic [1:0]     dec_kind;
    logic [3:0]     need_q;
    logic [3:0]     cnt_q;
    logic [2:0]     pos_q;
    logic           is_id_q;
    logic           wel_q;
    logic [ADDR_BITS-1:0] addr_q;
    logic [7:0]     reply_byte;
    logic           reply_last;
    logic           xfer;
    logic           shift_en;
    logic           inc_en;
    logic           collect_done;

    assign xfer         = rx_valid && !cs_n;
    assign shift_en     = xfer && (state_q == ST_COLLECT) && (cnt_q < 4'd3);
    assign inc_en       = xfer && ((state_q == ST_READ) || (state_q == ST_PROG));
    assign collect_done = (4'(cnt_q + 4'd1) == need_q);
    assign rd_addr      = addr_q;
    assign erase_addr   = addr_q;

    sfc_opcode_decode #(.MFR_ID(MFR_ID)) u_dec (
        .opcode   (rx_byte),
        .op_class (dec_class),
        .need     (dec_need),
        .ekind    (dec_kind)
    );

    sfc_addr_counter #(.ADDR_BITS(ADDR_BITS)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .inc_en   (inc_en),
        .byte_in  (rx_byte),
        .addr     (addr_q)
    );

    sfc_reply_mux #(.MFR_ID(MFR_ID), .DEV_ID(DEV_ID), .EXT_ID(EXT_ID)) u_reply (
        .is_id    (is_id_q),
        .idx      (pos_q),
        .wel      (wel_q),
        .byte_out (reply_byte),
        .last     (reply_last)
    );

    // command state machine, write-enable latch and request pulses
    always_ff @(posedge clk) begin
        prog_req  <= 1'b0;
        erase_req <= 1'b0;
        err       <= 1'b0;
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cls_q      <= OC_NOP;
            need_q     <= '0;
            cnt_q      <= '0;
            pos_q      <= '0;
            is_id_q    <= 1'b0;
            wel_q      <= 1'b0;
            tx_byte    <= 8'h00;
            prog_addr  <= '0;
            prog_data  <= 8'h00;
            erase_kind <= EK_4K;
        end else if (cs_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            pos_q   <= '0;
        end else if (rx_valid) begin
            tx_byte <= 8'h00;
            case (state_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                    pos_q <= '0;
                    case (dec_class)
                        OC_READ, OC_PROG, OC_ERASE: begin
                            cls_q      <= dec_class;
                            need_q     <= dec_need;
                            erase_kind <= dec_kind;
                            state_q    <= ST_COLLECT;
                        end
                        OC_WRSR: begin
                            if (wel_q) begin
                                cls_q   <= OC_WRSR;
                                need_q  <= dec_need;
                                state_q <= ST_COLLECT;
                            end
                        end
                        OC_WREN: wel_q <= 1'b1;
                        OC_WRDI: wel_q <= 1'b0;
                        OC_STATUS, OC_ID: begin
                            is_id_q <= (dec_class == OC_ID);
                            state_q <= ST_REPLY;
                        end
                        OC_BULK: begin
                            if (wel_q) begin
                                erase_req  <= 1'b1;
                                erase_kind <= EK_WHOLE;
                            end else begin
                                err <= 1'b1;
                            end
                        end
                        OC_BAD:  err <= 1'b1;
                        default: ;
                    endcase
                end
                ST_COLLECT: begin
                    cnt_q <= cnt_q + 4'd1;
                    if (collect_done) begin
                        state_q <= ST_IDLE;
                        case (cls_q)
                            OC_READ: state_q <= ST_READ;
                            OC_PROG: state_q <= ST_PROG;
                            OC_ERASE: begin
                                if (wel_q) erase_req <= 1'b1;
                                else       err       <= 1'b1;
                            end
                            OC_WRSR: wel_q <= 1'b0;
                            default: ;
                        endcase
                    end
                end
                ST_READ: tx_byte <= rd_data;
                ST_PROG: begin
                    prog_req  <= 1'b1;
                    prog_addr <= addr_q;
                    prog_data <= rx_byte;
                end
                ST_REPLY: begin
                    tx_byte <= reply_byte;
                    pos_q   <= pos_q + 3'd1;
                    if (reply_last) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sfc_checker.sv
// Property checker for the flash command sequencer, bound to every instance.
// Assumes: reset is asserted at start-up.
module sfc_checker #(
    parameter int ADDR_BITS = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cs_n,
    input logic                 rx_valid,
    input logic [7:0]           tx_byte,
    input logic                 prog_req,
    input logic                 erase_req,
    input logic                 err,
    input logic                 wel,
    input logic [2:0]           state,
    input logic [ADDR_BITS-1:0] rd_addr
);
    // deselect forces idle on the following cycle
    assert_cs_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (state == 3'd0));

    // an erase request only follows a set write-enable latch
    assert_erase_needs_wel_R9: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> $past(wel));

    // a program pulse only follows an accepted transfer
    assert_prog_on_xfer_R5: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |-> ($past(rx_valid) && !$past(cs_n)));

    // request and error pulses are mutually exclusive
    assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_req, erase_req, err}));

    // returned byte moves only on an accepted transfer
    assert_tx_stable_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_valid && !cs_n) |=> $stable(tx_byte));

    // read transfers advance the address by one with wrap
    assert_read_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == 3'd2) && rx_valid && !cs_n) |=>
            (rd_addr == ADDR_BITS'($past(rd_addr) + 1'b1)));
endmodule

bind spi_flash_cmd_seq sfc_checker #(.ADDR_BITS(ADDR_BITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .rx_valid  (rx_valid),
    .tx_byte   (tx_byte),
    .prog_req  (prog_req),
    .erase_req (erase_req),
    .err       (err),
    .wel       (wel_q),
    .state     (state_q),
    .rd_addr   (rd_addr)
);

// File: tb/sim_spi_flash_cmd_seq.sv
// Bench: u0 uses manufacturer 0x20 without extended ID, u1 uses 0xEF with
// extended ID 0x4D01; both see the same byte stream.
module sim_spi_flash_cmd_seq;
    localparam int AB = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;

    logic [7:0] tx0, tx1, rd0, rd1;
    logic [AB-1:0] ra0, ra1, pa0, pa1, ea0, ea1;
    logic [7:0] pd0, pd1;
    logic pr0, pr1, er0, er1, e0, e1;
    logic [1:0] ek0, ek1;

    int nchk = 0;
    int nfail = 0;

    always #4 clk = ~clk;

    function automatic logic [7:0] mem(input logic [AB-1:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    assign rd0 = mem(ra0);
    assign rd1 = mem(ra1);

    spi_flash_cmd_seq #(.ADDR_BITS(AB)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_byte(tx0), .rd_addr(ra0), .rd_data(rd0), .prog_req(pr0), .prog_addr(pa0),
        .prog_data(pd0), .erase_req(er0), .erase_kind(ek0), .erase_addr(ea0), .err(e0));

    spi_flash_cmd_seq #(.ADDR_BITS(AB), .MFR_ID(8'hEF), .DEV_ID(16'h4016),
                        .EXT_ID(16'h4D01)) u1 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_byte(tx1), .rd_addr(ra1), .rd_data(rd1), .prog_req(pr1), .prog_addr(pa1),
        .prog_data(pd1), .erase_req(er1), .erase_kind(ek1), .erase_addr(ea1), .err(e1));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one accepted transfer; outputs are sampled on the following falling edge
    task automatic xfer(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_byte  = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic reselect();
        @(negedge clk);
        cs_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        cs_n = 1'b0;
    endtask

    task automatic send_addr(input logic [23:0] a);
        xfer(a[23:16]);
        xfer(a[15:8]);
        xfer(a[7:0]);
    endtask

    function automatic int dummies(input logic [7:0] op);
        return (op == 8'h03) ? 0 : 1;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=%0d expected=%0d", nchk, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 tx", {24'h0, tx0}, 32'h00);
        chk("R1 pulses", {29'h0, pr0, er0, e0}, 32'h0);
        cs_n = 1'b0;
        xfer(8'h05); xfer(8'h00);
        chk("R1 latch clear", {24'h0, tx0}, 32'h00);

        // R6 latch set/clear, R12 kept across deselect
        reselect(); xfer(8'h06); reselect();
        xfer(8'h05); xfer(8'h00);
        chk("R6 status set", {24'h0, tx0}, 32'h02);
        chk("R12 latch kept", {24'h0, tx1}, 32'h02);
        reselect(); xfer(8'h04); xfer(8'h05); xfer(8'h00);
        chk("R6 status clear", {24'h0, tx0}, 32'h00);

        // R7 identification, 3 vs 5 bytes
        reselect(); xfer(8'h9F);
        chk("R13 opcode tx", {24'h0, tx0}, 32'h00);
        xfer(8'h00); chk("R7 u0 b0", {24'h0, tx0}, 32'h20); chk("R7 u1 b0", {24'h0, tx1}, 32'hEF);
        xfer(8'h00); chk("R7 u0 b1", {24'h0, tx0}, 32'hBA); chk("R7 u1 b1", {24'h0, tx1}, 32'h40);
        xfer(8'h00); chk("R7 u0 b2", {24'h0, tx0}, 32'h16); chk("R7 u1 b2", {24'h0, tx1}, 32'h16);
        xfer(8'h00); chk("R7 u0 idle", {24'h0, tx0}, 32'h00); chk("R7 u1 b3", {24'h0, tx1}, 32'h4D);
        xfer(8'h00); chk("R7 u1 b4", {24'h0, tx1}, 32'h01);
        chk("R11 nop no err", {31'h0, e0}, 32'h0);
        xfer(8'h9F); xfer(8'h00);
        chk("R7 both idle", {tx0, tx1}, {8'h20, 8'hEF});

        // R2 R4 random reads
        for (int i = 0; i < 24; i++) begin
            logic [7:0] op;
            logic [23:0] a;
            int n;
            case ($urandom % 4)
                0: op = 8'h03;
                1: op = 8'h0B;
                2: op = 8'h3B;
                default: op = 8'h6B;
            endcase
            a = 24'($urandom);
            n = 1 + int'($urandom % 8);
            reselect(); xfer(op); send_addr(a);
            for (int d = 0; d < dummies(op); d++) xfer(8'hA5);
            for (int k = 0; k < n; k++) begin
                xfer(8'($urandom));
                chk("R2 R4 read u0", {24'h0, tx0}, {24'h0, mem(AB'(a) + AB'(k))});
                chk("R2 read u1", {24'h0, tx1}, {24'h0, mem(AB'(a) + AB'(k))});
            end
        end

        // R4 wrap at top, upper address byte dropped
        reselect(); xfer(8'h03); send_addr(24'h7FFFFE);
        xfer(8'h00); chk("R4 wrap 0", {24'h0, tx0}, {24'h0, mem(16'hFFFE)});
        xfer(8'h00); chk("R4 wrap 1", {24'h0, tx0}, {24'h0, mem(16'hFFFF)});
        xfer(8'h00); chk("R4 wrap 2", {24'h0, tx0}, {24'h0, mem(16'h0000)});

        // R3 0xBB: u1 4 bytes, u0 5 bytes
        reselect(); xfer(8'hBB); send_addr(24'h001234); xfer(8'h00);
        xfer(8'h00);
        chk("R3 BB u1 first", {24'h0, tx1}, {24'h0, mem(16'h1234)});
        chk("R3 BB u0 still collecting", {24'h0, tx0}, 32'h00);
        xfer(8'h00);
        chk("R3 BB u0 first", {24'h0, tx0}, {24'h0, mem(16'h1234)});
        chk("R3 BB u1 second", {24'h0, tx1}, {24'h0, mem(16'h1235)});

        // R3 0xEB: u1 6 bytes, u0 8 bytes
        reselect(); xfer(8'hEB); send_addr(24'h00ABC0);
        xfer(8'h00); xfer(8'h00); xfer(8'h00);
        xfer(8'h00);
        chk("R3 EB u1 first", {24'h0, tx1}, {24'h0, mem(16'hABC0)});
        chk("R3 EB u0 wait", {24'h0, tx0}, 32'h00);
        xfer(8'h00); xfer(8'h00);
        chk("R3 EB u0 first", {24'h0, tx0}, {24'h0, mem(16'hABC0)});
        chk("R3 EB u1 third", {24'h0, tx1}, {24'h0, mem(16'hABC2)});

        // R5 random page programs
        for (int i = 0; i < 12; i++) begin
            logic [7:0] op;
            logic [23:0] a;
            int n;
            case ($urandom % 3)
                0: op = 8'h02;
                1: op = 8'hA2;
                default: op = 8'h32;
            endcase
            a = 24'($urandom);
            n = 1 + int'($urandom % 4);
            reselect(); xfer(op); send_addr(a);
            chk("R2 no early prog", {31'h0, pr0}, 32'h0);
            for (int k = 0; k < n; k++) begin
                logic [7:0] dv;
                dv = 8'($urandom);
                xfer(dv);
                chk("R5 prog req", {31'h0, pr0}, 32'h1);
                chk("R5 prog addr", {16'h0, pa0}, {16'h0, AB'(a) + AB'(k)});
                chk("R5 prog data", {24'h0, pd0}, {24'h0, dv});
                chk("R13 prog tx", {24'h0, tx0}, 32'h00);
            end
        end

        // R9 erase without latch
        reselect(); xfer(8'h04); reselect(); xfer(8'h20); send_addr(24'h003000);
        chk("R9 err no latch", {30'h0, er0, e0}, 32'h1);
        // R9 erase kinds with latch
        reselect(); xfer(8'h06); reselect(); xfer(8'hD8); send_addr(24'h124000);
        chk("R9 sector req", {30'h0, er0, e0}, 32'h2);
        chk("R9 sector kind", {30'h0, ek0}, 32'h2);
        chk("R9 sector addr", {16'h0, ea0}, 32'h4000);
        reselect(); xfer(8'h52); send_addr(24'h008000);
        chk("R9 32k kind", {29'h0, er0, ek0}, 32'h5);
        reselect(); xfer(8'h20); xfer(8'h00); xfer(8'h10);
        chk("R2 erase waits", {31'h0, er0}, 32'h0);
        xfer(8'h00);
        chk("R9 4k kind", {29'h0, er0, ek0}, 32'h4);

        // R10 whole-array erase
        reselect(); xfer(8'hC7);
        chk("R10 whole", {29'h0, er0, ek0}, 32'h7);
        reselect(); xfer(8'h04); xfer(8'hC7);
        chk("R10 no latch err", {30'h0, er0, e0}, 32'h1);

        // R8 status write
        reselect(); xfer(8'h06); reselect(); xfer(8'h01); xfer(8'h55);
        chk("R8 no err", {31'h0, e0}, 32'h0);
        reselect(); xfer(8'h05); xfer(8'h00);
        chk("R8 latch cleared", {24'h0, tx0}, 32'h00);
        reselect(); xfer(8'h01); xfer(8'h9F); xfer(8'h00);
        chk("R8 ignored without latch", {24'h0, tx0}, 32'h20);

        // R11 unknown opcode
        reselect(); xfer(8'hFF);
        chk("R11 unknown err", {31'h0, e0}, 32'h1);
        @(negedge clk);
        chk("R11 err one cycle", {31'h0, e0}, 32'h0);

        // R12 deselect mid-command, byte while deselected ignored
        reselect(); xfer(8'h06); reselect();
        xfer(8'h03); xfer(8'h00);
        @(negedge clk); cs_n = 1'b1;
        xfer(8'h9F);
        chk("R12 ignored tx", {24'h0, tx0}, 32'h00);
        @(negedge clk); cs_n = 1'b0;
        xfer(8'h05); xfer(8'h00);
        chk("R12 fresh opcode", {24'h0, tx0}, 32'h02);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule